// File: doc/BRIEF.md
# Per-Group Asymmetric 4-Bit Weight Quantizer

The block takes a stream of signed 8-bit weights and packs each run of `GROUP_SIZE` consecutive weights into unsigned 4-bit codes with one scale and one zero point per run. The quantizer works in two passes. While the weights arrive they are written into a group buffer, and the smallest and largest values are tracked. After the final weight of the group is in, one shared sequential divider first produces the scale and then the scale's reciprocal. The zero point is then derived from the minimum. In the second pass the buffered weights are read out in arrival order. Each weight leaves as a code, and the group's scale and zero point travel with every code as metadata.

A separate dequantize stream accepts a code, a zero point and a scale, and returns the signed product of the code offset and the scale one register stage later. The ingest side is stalled for the whole time a group is being emitted, because there is only one buffer.

Top module: `int4_group_quantizer`

## Requirements
- R1: While reset is asserted and directly after it, `in_ready_o` is 1, and `out_valid_o` and `dq_valid_o` are 0.
- R2: `in_ready_o` is 0 in every cycle in which `out_valid_o` is 1. No weight is taken from the time the last weight of a group is accepted until the last code of that group is accepted.
- R3: The scale is unsigned fixed point with 8 fractional bits: scale = floor((max - min) * 256 / 15). When max equals min, the scale is 1, which is the smallest nonzero value. The scale is never 0.
- R4: With recip = floor(2^24 / scale), the zero point is clip(floor((-min * recip + 32768) / 65536), 0, 15).
- R5: Each code is clip(floor((w * recip + 32768) / 65536) + zero_point, 0, 15), where w is the signed weight.
- R6: For a group in which every weight is equal, every code equals the zero point.
- R7: Codes leave in the order in which their weights arrived. `out_last_o` is 1 only on the final code of a group. Scale and zero point stay the same for all codes of a group.
- R8: While `out_valid_o` is 1 and `out_ready_i` is 0, code, scale, zero point and last stay unchanged and valid stays 1.
- R9: The dequantize stream returns (code - zero_point) * scale as a signed value with 8 fractional bits, one cycle after acceptance. The output holds while it is stalled. `dq_ready_o` is 1 when the output register is empty or is being drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Weight valid |
| in_ready_o | output | 1 | Weight accepted when high together with valid |
| in_weight_i | input | 8 | Signed weight |
| out_valid_o | output | 1 | Code valid |
| out_ready_i | input | 1 | Downstream ready for codes |
| out_code_o | output | 4 | Unsigned code |
| out_scale_o | output | 16 | Group scale, 8 fractional bits |
| out_zero_o | output | 4 | Group zero point |
| out_last_o | output | 1 | Final code of the group |
| dq_valid_i | input | 1 | Dequantize request valid |
| dq_ready_o | output | 1 | Dequantize request accepted |
| dq_code_i | input | 4 | Code to expand |
| dq_zero_i | input | 4 | Zero point for the code |
| dq_scale_i | input | 16 | Scale for the code |
| dq_valid_o | output | 1 | Dequantized value valid |
| dq_ready_i | input | 1 | Downstream ready for values |
| dq_value_o | output | 22 | Signed value, 8 fractional bits |

## Verification
The hold assertions on the code stream concern only the block's own outputs, so `out_ready_i` may toggle freely. The divider assertion, however, assumes that no new division starts while one is still running. The control sequence guarantees this, because the ingest side is closed until the reciprocal is done. The dequantize hold property assumes the requester keeps its request stable until it is accepted. The bench keeps to these assumptions by changing inputs only on falling edges and by holding each request until it sees ready. It stalls the outputs under steady, periodic and pseudo-random ready patterns.

// File: rtl/qnt4_pkg.sv
package qnt4_pkg;
  typedef enum logic [1:0] {
    ST_LOAD,
    ST_SCALE,
    ST_RECIP,
    ST_EMIT
  } qnt_state_e;
endpackage

// File: rtl/qnt4_seq_div.sv
module qnt4_seq_div #(
  parameter int NUM_W = 25,
  parameter int DEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] num_q;
  logic [DEN_W-1:0] den_q, rem_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;
  logic [DEN_W:0]   trial;
  logic             q_bit;
  logic [DEN_W:0]   diff;

  always_comb begin
    trial = {rem_q, num_q[NUM_W-1]};
    diff  = trial - {1'b0, den_q};
    q_bit = (trial >= {1'b0, den_q});
  end

  // restoring: quotient bits shift in where dividend bits shift out
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      num_q  <= '0;
      den_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        num_q  <= num_i;
        den_q  <= den_i;
        rem_q  <= '0;
        cnt_q  <= CNT_W'(NUM_W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= q_bit ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
        num_q <= {num_q[NUM_W-2:0], q_bit};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quo_o  = num_q;

  a_r3_no_restart_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
  a_r3_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/qnt4_grp_buf.sv
module qnt4_grp_buf #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/qnt4_range_track.sv
module qnt4_range_track #(
  parameter int DATA_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic                     first_i,
  input  logic signed [DATA_W-1:0] data_i,
  output logic signed [DATA_W-1:0] min_o,
  output logic signed [DATA_W-1:0] max_o
);
  logic signed [DATA_W-1:0] min_q, max_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      min_q <= '0;
      max_q <= '0;
    end else if (en_i) begin
      if (first_i || data_i < min_q) min_q <= data_i;
      if (first_i || data_i > max_q) max_q <= data_i;
    end
  end

  assign min_o = min_q;
  assign max_o = max_q;

  a_r3_min_le_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && first_i) |=> (min_o <= max_o));
endmodule

// File: rtl/qnt4_round_clip.sv
module qnt4_round_clip #(
  parameter int IN_W    = 9,
  parameter int RECIP_W = 25,
  parameter int SHIFT   = 16,
  parameter int CODE_W  = 4
) (
  input  logic signed [IN_W-1:0]  val_i,
  input  logic [RECIP_W-1:0]      recip_i,
  input  logic [CODE_W-1:0]       off_i,
  output logic [CODE_W-1:0]       code_o
);
  localparam int PROD_W = IN_W + RECIP_W + 1;
  localparam logic signed [PROD_W-1:0] HALF   = PROD_W'(1) <<< (SHIFT - 1);
  localparam logic signed [PROD_W-1:0] QMAX_S = PROD_W'((1 << CODE_W) - 1);

  logic signed [PROD_W-1:0] val_x, rec_x, prod, rnd, shifted, sum;

  always_comb begin
    val_x   = PROD_W'(val_i);
    rec_x   = PROD_W'({1'b0, recip_i});
    prod    = val_x * rec_x;
    rnd     = prod + HALF;
    shifted = rnd >>> SHIFT;
    sum     = shifted + PROD_W'({1'b0, off_i});
    if (sum[PROD_W-1])    code_o = '0;
    else if (sum > QMAX_S) code_o = '1;
    else                   code_o = sum[CODE_W-1:0];
  end
endmodule

// File: rtl/qnt4_dequant.sv
module qnt4_dequant #(
  parameter int CODE_W  = 4,
  parameter int SCALE_W = 16,
  localparam int DQ_W   = CODE_W + SCALE_W + 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  output logic                   ready_o,
  input  logic [CODE_W-1:0]      code_i,
  input  logic [CODE_W-1:0]      zero_i,
  input  logic [SCALE_W-1:0]     scale_i,
  output logic                   valid_o,
  input  logic                   ready_i,
  output logic signed [DQ_W-1:0] value_o
);
  logic signed [DQ_W-1:0] diff_x, scl_x, prod;
  logic signed [DQ_W-1:0] value_q;
  logic                   valid_q;

  always_comb begin
    diff_x = DQ_W'($signed({1'b0, code_i})) - DQ_W'($signed({1'b0, zero_i}));
    scl_x  = DQ_W'({1'b0, scale_i});
    prod   = diff_x * scl_x;
  end

  assign ready_o = !valid_q || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      value_q <= '0;
    end else if (ready_o) begin
      valid_q <= valid_i;
      if (valid_i) value_q <= prod;
    end
  end

  assign valid_o = valid_q;
  assign value_o = value_q;

  a_r9_hold_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(value_o)));
  a_r9_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> valid_o);
endmodule

// File: rtl/int4_group_quantizer.sv
module int4_group_quantizer #(
  parameter int DATA_W       = 8,
  parameter int GROUP_SIZE   = 128,
  parameter int CODE_W       = 4,
  parameter int FRAC_W       = 8,
  parameter int RECIP_FRAC_W = 16,
  parameter int SCALE_W      = 16,
  localparam int DQ_W        = CODE_W + SCALE_W + 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   in_valid_i,
  output logic                   in_ready_o,
  input  logic [DATA_W-1:0]      in_weight_i,
  output logic                   out_valid_o,
  input  logic                   out_ready_i,
  output logic [CODE_W-1:0]      out_code_o,
  output logic [SCALE_W-1:0]     out_scale_o,
  output logic [CODE_W-1:0]      out_zero_o,
  output logic                   out_last_o,
  input  logic                   dq_valid_i,
  output logic                   dq_ready_o,
  input  logic [CODE_W-1:0]      dq_code_i,
  input  logic [CODE_W-1:0]      dq_zero_i,
  input  logic [SCALE_W-1:0]     dq_scale_i,
  output logic                   dq_valid_o,
  input  logic                   dq_ready_i,
  output logic [DQ_W-1:0]        dq_value_o
);
  import qnt4_pkg::*;

  localparam int IDX_W   = $clog2(GROUP_SIZE);
  localparam int RANGE_W = DATA_W + 1;
  localparam int NUM_W   = FRAC_W + RECIP_FRAC_W + 1;
  localparam int QMAX    = (1 << CODE_W) - 1;
  localparam logic [NUM_W-1:0] RECIP_NUM = {1'b1, {(NUM_W-1){1'b0}}};
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(GROUP_SIZE - 1);

  qnt_state_e state_q;
  logic [IDX_W-1:0]   idx_q;
  logic [SCALE_W-1:0] scale_q;
  logic [NUM_W-1:0]   recip_q;
  logic [CODE_W-1:0]  zero_q;
  logic               start_q;

  logic in_fire, out_fire, flat;
  logic signed [DATA_W-1:0]  min_w, max_w;
  logic signed [RANGE_W-1:0] min_x, max_x, neg_min, span_s, wt_x;
  logic [RANGE_W-1:0]        span_u;
  logic [NUM_W-1:0]          div_num, div_quo;
  logic [SCALE_W-1:0]        div_den;
  logic                      div_busy, div_done;
  logic [DATA_W-1:0]         rd_data;
  logic [CODE_W-1:0]         zero_calc, code_calc;

  assign in_ready_o  = (state_q == ST_LOAD);
  assign out_valid_o = (state_q == ST_EMIT);
  assign in_fire     = in_valid_i && in_ready_o;
  assign out_fire    = out_valid_o && out_ready_i;

  qnt4_grp_buf #(.DATA_W(DATA_W), .DEPTH(GROUP_SIZE)) u_buf (
    .clk_i     (clk_i),
    .wr_en_i   (in_fire),
    .wr_addr_i (idx_q),
    .wr_data_i (in_weight_i),
    .rd_addr_i (idx_q),
    .rd_data_o (rd_data)
  );

  qnt4_range_track #(.DATA_W(DATA_W)) u_range (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (in_fire),
    .first_i (idx_q == '0),
    .data_i  (in_weight_i),
    .min_o   (min_w),
    .max_o   (max_w)
  );

  always_comb begin
    min_x   = RANGE_W'(min_w);
    max_x   = RANGE_W'(max_w);
    neg_min = -min_x;
    span_s  = max_x - min_x;
    span_u  = span_s;
    flat    = (span_u == '0);
    wt_x    = RANGE_W'($signed(rd_data));
  end

  // one divider, two jobs: span*2^F/15 then 2^(F+R)/scale
  assign div_num = (state_q == ST_SCALE) ? NUM_W'({span_u, {FRAC_W{1'b0}}}) : RECIP_NUM;
  assign div_den = (state_q == ST_SCALE) ? SCALE_W'(QMAX) : scale_q;

  qnt4_seq_div #(.NUM_W(NUM_W), .DEN_W(SCALE_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_q),
    .num_i   (div_num),
    .den_i   (div_den),
    .busy_o  (div_busy),
    .done_o  (div_done),
    .quo_o   (div_quo)
  );

  qnt4_round_clip #(.IN_W(RANGE_W), .RECIP_W(NUM_W), .SHIFT(RECIP_FRAC_W), .CODE_W(CODE_W))
  u_zero (
    .val_i   (neg_min),
    .recip_i (div_quo),
    .off_i   ('0),
    .code_o  (zero_calc)
  );

  qnt4_round_clip #(.IN_W(RANGE_W), .RECIP_W(NUM_W), .SHIFT(RECIP_FRAC_W), .CODE_W(CODE_W))
  u_code (
    .val_i   (wt_x),
    .recip_i (recip_q),
    .off_i   (zero_q),
    .code_o  (code_calc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LOAD;
      idx_q   <= '0;
      scale_q <= SCALE_W'(1);
      recip_q <= '0;
      zero_q  <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      unique case (state_q)
        ST_LOAD: if (in_fire) begin
          if (idx_q == LAST_IDX) begin
            idx_q   <= '0;
            state_q <= ST_SCALE;
            start_q <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_SCALE: if (div_done) begin
          scale_q <= flat ? SCALE_W'(1) : div_quo[SCALE_W-1:0];
          state_q <= ST_RECIP;
          start_q <= 1'b1;
        end
        ST_RECIP: if (div_done) begin
          recip_q <= div_quo;
          zero_q  <= zero_calc;
          state_q <= ST_EMIT;
        end
        ST_EMIT: if (out_fire) begin
          if (idx_q == LAST_IDX) begin
            idx_q   <= '0;
            state_q <= ST_LOAD;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_LOAD;
      endcase
    end
  end

  assign out_code_o  = flat ? zero_q : code_calc;
  assign out_scale_o = scale_q;
  assign out_zero_o  = zero_q;
  assign out_last_o  = out_valid_o && (idx_q == LAST_IDX);

  qnt4_dequant #(.CODE_W(CODE_W), .SCALE_W(SCALE_W)) u_dq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (dq_valid_i),
    .ready_o (dq_ready_o),
    .code_i  (dq_code_i),
    .zero_i  (dq_zero_i),
    .scale_i (dq_scale_i),
    .valid_o (dq_valid_o),
    .ready_i (dq_ready_i),
    .value_o (dq_value_o)
  );

  a_r2_no_ingest_emit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);
  a_r3_scale_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_scale_o != '0));
  a_r3_scale_fits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SCALE && div_done) |-> (div_quo[NUM_W-1:SCALE_W] == '0));
  a_r3_div_idle_ingest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> !div_busy);
  a_r8_hold_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_code_o)
      && $stable(out_scale_o) && $stable(out_zero_o) && $stable(out_last_o)));
  a_r7_meta_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_fire && !out_last_o) |=> ($stable(out_scale_o) && $stable(out_zero_o)));
  a_r7_last_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_fire && out_last_o) |=> (!out_valid_o && in_ready_o));
endmodule

// File: tb/int4_group_quantizer_test.sv
module int4_group_quantizer_test;
  localparam int GS = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [7:0] in_weight = '0;
  logic out_valid, out_ready = 1'b0, out_last;
  logic [3:0] out_code, out_zero;
  logic [15:0] out_scale;
  logic dq_valid = 1'b0, dq_ready, dq_valid_o, dq_ready_i = 1'b0;
  logic [3:0] dq_code = '0, dq_zero = '0;
  logic [15:0] dq_scale = '0;
  logic [21:0] dq_value;

  int checks = 0;
  int errors = 0;
  int grp [GS];
  int exp_code [GS];
  int exp_scale, exp_zero;
  int unsigned lcg = 32'h1234_5678;

  always #10 clk = ~clk;

  int4_group_quantizer uut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_weight_i(in_weight),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_code_o(out_code),
    .out_scale_o(out_scale), .out_zero_o(out_zero), .out_last_o(out_last),
    .dq_valid_i(dq_valid), .dq_ready_o(dq_ready), .dq_code_i(dq_code),
    .dq_zero_i(dq_zero), .dq_scale_i(dq_scale),
    .dq_valid_o(dq_valid_o), .dq_ready_i(dq_ready_i), .dq_value_o(dq_value)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int clip15(input longint v);
    if (v < 0) return 0;
    if (v > 15) return 15;
    return int'(v);
  endfunction

  function automatic bit ready_pat(input int mode, input int cyc);
    if (mode == 0) return 1'b1;
    if (mode == 1) return (cyc % 3) != 0;
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg[16];
  endfunction

  // expected values straight from R3, R4, R5, R6
  task automatic model();
    int mn, mx;
    longint rc;
    mn = grp[0]; mx = grp[0];
    for (int i = 1; i < GS; i++) begin
      if (grp[i] < mn) mn = grp[i];
      if (grp[i] > mx) mx = grp[i];
    end
    exp_scale = (mx == mn) ? 1 : ((mx - mn) * 256) / 15;
    rc = (longint'(1) << 24) / exp_scale;
    exp_zero = clip15(((longint'(-mn) * rc) + 32768) >>> 16);
    for (int i = 0; i < GS; i++)
      exp_code[i] = (mx == mn) ? exp_zero
                  : clip15((((longint'(grp[i]) * rc) + 32768) >>> 16) + exp_zero);
  endtask

  task automatic send_group();
    for (int i = 0; i < GS; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_weight = grp[i][7:0];
      #1;
      while (!in_ready) begin
        @(negedge clk);
        #1;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic recv_group(input int mode, input string tag);
    int j = 0, cyc = 0;
    bit pend = 0;
    logic [3:0] h_code, h_zero;
    logic [15:0] h_scale;
    logic h_last;
    while (j < GS) begin
      @(negedge clk);
      out_ready = ready_pat(mode, cyc);
      cyc++;
      #1;
      if (out_valid && in_ready) chk(0, "R2", "in_ready during emit", 1, 0);
      if (pend && out_valid) begin
        chk(out_code == h_code && out_scale == h_scale && out_zero == h_zero
            && out_last == h_last, "R8", "held outputs changed",
            out_code, h_code);
        pend = 0;
      end
      if (out_valid) begin
        if (!out_ready) begin
          pend = 1; h_code = out_code; h_scale = out_scale;
          h_zero = out_zero; h_last = out_last;
        end else begin
          chk(out_code == exp_code[j], tag, $sformatf("code %0d", j), out_code, exp_code[j]);
          chk(out_scale == exp_scale, "R3", "scale", out_scale, exp_scale);
          chk(out_zero == exp_zero, "R4", "zero point", out_zero, exp_zero);
          chk(out_last == (j == GS - 1), "R7", $sformatf("last at %0d", j), out_last, j == GS - 1);
          j++;
        end
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
    #1;
    chk(!out_valid && in_ready, "R2", "ingest reopens after group", in_ready, 1);
  endtask

  task automatic run_group(input int mode, input string tag);
    model();
    fork
      send_group();
      recv_group(mode, tag);
    join
  endtask

  task automatic t_reset();
    #1;
    chk(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    chk(dq_valid_o == 1'b0, "R1", "dq_valid in reset", dq_valid_o, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1", "state after reset", in_ready, 1);
  endtask

  task automatic t_ramp();
    for (int i = 0; i < GS; i++) grp[i] = i - 64;
    run_group(0, "R5");
  endtask

  task automatic t_flat_neg();
    for (int i = 0; i < GS; i++) grp[i] = -5;
    run_group(1, "R6");
  endtask

  task automatic t_flat_zero();
    for (int i = 0; i < GS; i++) grp[i] = 0;
    run_group(0, "R6");
  endtask

  task automatic t_extremes();
    for (int i = 0; i < GS; i++)
      grp[i] = (i % 4 == 0) ? -128 : (i % 4 == 1) ? 127 : ((i * 37) % 256) - 128;
    run_group(2, "R5");
  endtask

  task automatic t_positive();
    for (int i = 0; i < GS; i++) grp[i] = 20 + (i * 13) % 101;
    run_group(1, "R5");
  endtask

  task automatic t_negative();
    for (int i = 0; i < GS; i++) grp[i] = -100 + (i * 11) % 91;
    run_group(2, "R5");
  endtask

  task automatic t_dequant(input int zp, input int sc, input int mode);
    int n = 24;
    fork
      begin
        for (int i = 0; i < n; i++) begin
          @(negedge clk);
          dq_valid = 1'b1;
          dq_code = 4'((i * 7) % 16);
          dq_zero = 4'(zp);
          dq_scale = 16'(sc);
          #1;
          while (!dq_ready) begin
            @(negedge clk);
            #1;
          end
        end
        @(negedge clk);
        dq_valid = 1'b0;
      end
      begin
        int j = 0, cyc = 0;
        bit pend = 0;
        logic [21:0] held;
        while (j < n) begin
          @(negedge clk);
          dq_ready_i = ready_pat(mode, cyc);
          cyc++;
          #1;
          if (pend && dq_valid_o) begin
            chk(dq_value == held, "R9", "held value changed", $signed(dq_value), $signed(held));
            pend = 0;
          end
          if (dq_valid_o) begin
            if (!dq_ready_i) begin
              pend = 1; held = dq_value;
            end else begin
              chk($signed(dq_value) == (((j * 7) % 16) - zp) * sc, "R9",
                  $sformatf("value %0d", j), $signed(dq_value), (((j * 7) % 16) - zp) * sc);
              j++;
            end
          end
        end
        @(negedge clk);
        dq_ready_i = 1'b0;
      end
    join
  endtask

  initial begin
    t_reset();
    t_ramp();
    t_flat_neg();
    t_extremes();
    t_positive();
    t_negative();
    t_flat_zero();
    t_dequant(9, 4352, 0);
    t_dequant(0, 1, 1);
    t_dequant(15, 1536, 2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R7 watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule